// File: doc/BRIEF.md
# PWM Fault Brake Input Conditioner

This block sits between the fault sources of a motor-drive system and one complementary PWM output pair. It gathers six fault sources (two external brake pins, two analog comparator outputs, an ADC result-monitor flag and a combined system-fail line). It conditions them and, when any enabled source fires, overrides both outputs of the pair with programmed safe levels. While no brake is active, the two PWM generator outputs pass through unchanged.

Brake pins go through an optional polarity inverter and then a digital noise filter. The filter samples on a clock divided down from the system clock by a power of two. Comparator faults can be masked by a leading-edge blanking window, which opens on a selected edge of PWM channels 0, 2 or 4 to hide the switching spike. Each source can drive a latching brake path, a following brake path, or both. Software can also request either kind of brake through a trigger word.

Top module: `pwm_brake_cond`

## Requirements
- R1: During and after reset, with no fault applied, `brakeActive` and `edgeFlag` are 0 and `outA`/`outB` equal `pwmA`/`pwmB`.
- R2: `edgeFlag` rises at the first clock edge at which an edge-enabled conditioned source is high. It then stays high until a clock edge that samples `edgeFlagClr` high while no edge-enabled source is high.
- R3: A level-enabled source that is high at a clock edge holds the brake from that edge onward. The brake releases at the first clock edge sampling `periodEnd` high with no level-enabled source high. A `periodEnd` while a source is still high does not release it.
- R4: Source index order in `edgeEn` and `levelEn` is fixed: bit 0 pin 0, bit 1 pin 1, bit 2 comparator 0, bit 3 comparator 1, bit 4 ADC monitor, bit 5 system fail. A source whose two enable bits are both 0 has no effect on the outputs.
- R5: When `pinInvert[i]` is 1, pin i counts as active when low. The inversion is applied ahead of the noise filter.
- R6: A brake pin level is accepted only after it has differed from the filtered level on `filtCount` consecutive sample ticks, with 0 behaving as 1. With a tick every cycle and `filtCount`=3, a change driven before edge k raises the edge brake after edge k+3. A two-tick pulse is rejected.
- R7: With divider select n, sample ticks occur once every 2^n system clocks, for n from 0 to 7.
- R8: `blankType` selects the edge of the channels enabled in `blankSrcEn` that opens the blanking window: 0 rising, 1 falling, 2 either, 3 none. The window covers the `blankLen` cycles following the triggering clock edge, and comparator sources are ignored inside it. Pins, ADC monitor and system fail are never blanked.
- R9: A cycle with `swTrigWrite` high and `swTrig` bit `PAIR_IDX` set acts as an edge-type fault. Bit `8+PAIR_IDX` acts as a level-type fault. Bits of other pairs have no effect.
- R10: In every cycle in which `brakeActive` is 1, `outA` equals `brkLvlA` and `outB` equals `brkLvlB`, with no added register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | 2 | External brake pins |
| cmpIn | input | 2 | Analog comparator outputs |
| adcMon | input | 1 | ADC result-monitor fault flag |
| sysFail | input | 1 | Combined system-fail condition |
| pinInvert | input | 2 | Per-pin polarity inversion |
| divSel | input | 3 | Noise filter divider select (2^n) |
| filtCount | input | FILT_W | Required stable sample ticks |
| edgeEn | input | 6 | Latching brake enable per source |
| levelEn | input | 6 | Following brake enable per source |
| chanOut | input | 3 | PWM channel 0, 2, 4 outputs for blanking |
| blankSrcEn | input | 3 | Blanking channel select |
| blankType | input | 2 | Blanking trigger edge type |
| blankLen | input | BLANK_W | Blanking window length in cycles |
| swTrigWrite | input | 1 | Software trigger strobe |
| swTrig | input | 16 | Software trigger word |
| edgeFlagClr | input | 1 | Clear pulse for the latched flag |
| periodEnd | input | 1 | PWM period boundary pulse |
| pwmA | input | 1 | Generator output A |
| pwmB | input | 1 | Generator output B |
| brkLvlA | input | 1 | Safe level for output A |
| brkLvlB | input | 1 | Safe level for output B |
| outA | output | 1 | Conditioned output A |
| outB | output | 1 | Conditioned output B |
| brakeActive | output | 1 | Any brake in force |
| edgeFlag | output | 1 | Sticky latched brake flag |

## Verification
The bench builds the block with `PAIR_IDX`=1, so the trigger word is decoded at bits 1 and 9, and a write to bits 0 and 8 shows that another pair's request is ignored. It uses `FILT_W`=4 and `BLANK_W`=6. These widths keep filter thresholds and blanking windows to a few cycles, so the exact cycle a filtered pin is accepted and both ends of the blanking window can be sampled directly. Divider select values 0 and 2 bound the acceptance time of the filter tick against the free-running divider phase.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int NPIN = 2;
  localparam int NCMP = 2;
  localparam int NSRC = NPIN + NCMP + 2;
  localparam int NBLK = 3;
  localparam int SWTRIG_W = 16;
  localparam int SWLEVEL_OFS = 8;

  typedef enum logic [1:0] {
    BLK_RISE = 2'd0,
    BLK_FALL = 2'd1,
    BLK_BOTH = 2'd2,
    BLK_NONE = 2'd3
  } blkType_e;

  typedef struct packed {
    logic            sys;
    logic            adc;
    logic [NCMP-1:0] cmpLvl;
    logic [NPIN-1:0] pinLvl;
  } faultStrobe_t;
endpackage

// File: rtl/brk_pin_filter.sv
module brk_pin_filter #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  logic          rawIn,
  input  logic          invert,
  input  logic [CW-1:0] thresh,
  output logic          filtOut
);
  logic          lvl;
  logic [CW-1:0] runCnt;
  logic [CW:0]   nextRun;

  assign lvl     = rawIn ^ invert;
  assign nextRun = {1'b0, runCnt} + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtOut <= 1'b0;
      runCnt  <= '0;
    end else if (tick) begin
      if (lvl == filtOut) begin
        runCnt <= '0;
      end else if (nextRun >= {1'b0, thresh}) begin
        filtOut <= lvl;
        runCnt  <= '0;
      end else begin
        runCnt <= nextRun[CW-1:0];
      end
    end
  end
endmodule

// File: rtl/brk_datapath.sv
module brk_datapath
  import brk_pkg::*;
#(
  parameter int FILT_W    = 4,
  parameter int BLANK_W   = 8,
  parameter int DIVSEL_W  = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NPIN-1:0]     pinIn,
  input  logic [NCMP-1:0]     cmpIn,
  input  logic                adcMon,
  input  logic                sysFail,
  input  logic [NPIN-1:0]     pinInvert,
  input  logic [DIVSEL_W-1:0] divSel,
  input  logic [FILT_W-1:0]   filtCount,
  input  logic [NBLK-1:0]     chanOut,
  input  logic [NBLK-1:0]     blankSrcEn,
  input  logic [1:0]          blankType,
  input  logic [BLANK_W-1:0]  blankLen,
  output faultStrobe_t        stat
);
  localparam int DIV_W = (2 ** DIVSEL_W) - 1;

  logic [DIV_W-1:0]   divCnt;
  logic [DIV_W-1:0]   divMask;
  logic               tick;
  logic [NPIN-1:0]    pinFilt;
  logic [NBLK-1:0]    prevChan;
  logic [NBLK-1:0]    riseHit;
  logic [NBLK-1:0]    fallHit;
  logic               blankHit;
  logic [BLANK_W-1:0] blankCnt;
  logic               blanking;

  // sample-clock divider: one tick every 2^divSel cycles
  assign divMask = DIV_W'((32'd1 << divSel) - 32'd1);
  assign tick    = (divCnt & divMask) == '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= divCnt + 1'b1;
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    brk_pin_filter #(.CW(FILT_W)) filt_i (
      .clk     (clk),
      .rstN    (rstN),
      .tick    (tick),
      .rawIn   (pinIn[i]),
      .invert  (pinInvert[i]),
      .thresh  (filtCount),
      .filtOut (pinFilt[i])
    );
  end

  // leading-edge blanking
  assign riseHit = chanOut & ~prevChan & blankSrcEn;
  assign fallHit = ~chanOut & prevChan & blankSrcEn;

  always_comb begin
    case (blkType_e'(blankType))
      BLK_RISE: blankHit = |riseHit;
      BLK_FALL: blankHit = |fallHit;
      BLK_BOTH: blankHit = |(riseHit | fallHit);
      default:  blankHit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevChan <= '0;
      blankCnt <= '0;
    end else begin
      prevChan <= chanOut;
      if (blankHit)            blankCnt <= blankLen;
      else if (blankCnt != '0) blankCnt <= blankCnt - 1'b1;
    end
  end

  assign blanking = blankCnt != '0;

  assign stat.pinLvl = pinFilt;
  assign stat.cmpLvl = cmpIn & ~{NCMP{blanking}};
  assign stat.adc    = adcMon;
  assign stat.sys    = sysFail;
endmodule

// File: rtl/brk_control.sv
module brk_control
  import brk_pkg::*;
#(
  parameter int PAIR_IDX = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  faultStrobe_t        stat,
  input  logic [NSRC-1:0]     edgeEn,
  input  logic [NSRC-1:0]     levelEn,
  input  logic                swTrigWrite,
  input  logic [SWTRIG_W-1:0] swTrig,
  input  logic                edgeFlagClr,
  input  logic                periodEnd,
  input  logic                pwmA,
  input  logic                pwmB,
  input  logic                brkLvlA,
  input  logic                brkLvlB,
  output logic                outA,
  output logic                outB,
  output logic                brakeActive,
  output logic                edgeFlag
);
  logic [NSRC-1:0] srcVec;
  logic            swEdge;
  logic            swLevel;
  logic            edgeHit;
  logic            levelHit;
  logic            levelHold;
  logic            unusedSwBits;

  assign srcVec       = {stat.sys, stat.adc, stat.cmpLvl, stat.pinLvl};
  assign swEdge       = swTrigWrite & swTrig[PAIR_IDX];
  assign swLevel      = swTrigWrite & swTrig[SWLEVEL_OFS + PAIR_IDX];
  assign unusedSwBits = ^swTrig;
  assign edgeHit      = (|(srcVec & edgeEn)) | swEdge;
  assign levelHit     = (|(srcVec & levelEn)) | swLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeFlag  <= 1'b0;
      levelHold <= 1'b0;
    end else begin
      if (edgeHit)          edgeFlag <= 1'b1;
      else if (edgeFlagClr) edgeFlag <= 1'b0;
      if (levelHit)         levelHold <= 1'b1;
      else if (periodEnd)   levelHold <= 1'b0;
    end
  end

  assign brakeActive = edgeFlag | levelHold;
  assign outA        = brakeActive ? brkLvlA : pwmA;
  assign outB        = brakeActive ? brkLvlB : pwmB;
endmodule

// File: rtl/pwm_brake_cond.sv
module pwm_brake_cond
  import brk_pkg::*;
#(
  parameter int PAIR_IDX = 0,
  parameter int FILT_W   = 4,
  parameter int BLANK_W  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NPIN-1:0]     pinIn,
  input  logic [NCMP-1:0]     cmpIn,
  input  logic                adcMon,
  input  logic                sysFail,
  input  logic [NPIN-1:0]     pinInvert,
  input  logic [2:0]          divSel,
  input  logic [FILT_W-1:0]   filtCount,
  input  logic [NSRC-1:0]     edgeEn,
  input  logic [NSRC-1:0]     levelEn,
  input  logic [NBLK-1:0]     chanOut,
  input  logic [NBLK-1:0]     blankSrcEn,
  input  logic [1:0]          blankType,
  input  logic [BLANK_W-1:0]  blankLen,
  input  logic                swTrigWrite,
  input  logic [SWTRIG_W-1:0] swTrig,
  input  logic                edgeFlagClr,
  input  logic                periodEnd,
  input  logic                pwmA,
  input  logic                pwmB,
  input  logic                brkLvlA,
  input  logic                brkLvlB,
  output logic                outA,
  output logic                outB,
  output logic                brakeActive,
  output logic                edgeFlag
);
  faultStrobe_t stat;

  brk_datapath #(
    .FILT_W   (FILT_W),
    .BLANK_W  (BLANK_W),
    .DIVSEL_W (3)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .pinIn      (pinIn),
    .cmpIn      (cmpIn),
    .adcMon     (adcMon),
    .sysFail    (sysFail),
    .pinInvert  (pinInvert),
    .divSel     (divSel),
    .filtCount  (filtCount),
    .chanOut    (chanOut),
    .blankSrcEn (blankSrcEn),
    .blankType  (blankType),
    .blankLen   (blankLen),
    .stat       (stat)
  );

  brk_control #(.PAIR_IDX(PAIR_IDX)) ctl_i (
    .clk         (clk),
    .rstN        (rstN),
    .stat        (stat),
    .edgeEn      (edgeEn),
    .levelEn     (levelEn),
    .swTrigWrite (swTrigWrite),
    .swTrig      (swTrig),
    .edgeFlagClr (edgeFlagClr),
    .periodEnd   (periodEnd),
    .pwmA        (pwmA),
    .pwmB        (pwmB),
    .brkLvlA     (brkLvlA),
    .brkLvlB     (brkLvlB),
    .outA        (outA),
    .outB        (outB),
    .brakeActive (brakeActive),
    .edgeFlag    (edgeFlag)
  );
endmodule

// File: rtl/brk_checker.sv
module brk_checker
  import brk_pkg::*;
#(
  parameter int PAIR_IDX = 0
) (
  input logic                clk,
  input logic                rstN,
  input logic [NPIN-1:0]     pinIn,
  input logic [NPIN-1:0]     pinInvert,
  input logic [NSRC-1:0]     edgeEn,
  input logic                swTrigWrite,
  input logic [SWTRIG_W-1:0] swTrig,
  input logic                edgeFlagClr,
  input logic                periodEnd,
  input logic                brakeActive,
  input logic                edgeFlag,
  input faultStrobe_t        stat
);
  logic [NSRC-1:0] srcVec;
  assign srcVec = {stat.sys, stat.adc, stat.cmpLvl, stat.pinLvl};

  // R2
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (edgeFlag && !edgeFlagClr) |=> edgeFlag);

  // R3
  brake_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(brakeActive) |-> $past(periodEnd || edgeFlagClr));

  // R4
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(edgeFlag) |-> $past((|(srcVec & edgeEn)) || (swTrigWrite && swTrig[PAIR_IDX])));

  // R6
  filt_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(stat.pinLvl[0]) |-> ($past(pinIn[0] ^ pinInvert[0]) == stat.pinLvl[0]));
endmodule

bind pwm_brake_cond brk_checker #(.PAIR_IDX(PAIR_IDX)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .pinIn       (pinIn),
  .pinInvert   (pinInvert),
  .edgeEn      (edgeEn),
  .swTrigWrite (swTrigWrite),
  .swTrig      (swTrig),
  .edgeFlagClr (edgeFlagClr),
  .periodEnd   (periodEnd),
  .brakeActive (brakeActive),
  .edgeFlag    (edgeFlag),
  .stat        (stat)
);

// File: tb/pwm_brake_cond_tb_top.sv
`timescale 1ns/1ps
module pwm_brake_cond_tb_top;
  localparam int FW = 4;
  localparam int BW = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  pinIn = '0, cmpIn = '0, pinInvert = '0;
  logic        adcMon = 0, sysFail = 0;
  logic [2:0]  divSel = '0;
  logic [FW-1:0] filtCount = 4'd3;
  logic [5:0]  edgeEn = '0, levelEn = '0;
  logic [2:0]  chanOut = '0, blankSrcEn = '0;
  logic [1:0]  blankType = '0;
  logic [BW-1:0] blankLen = '0;
  logic        swTrigWrite = 0;
  logic [15:0] swTrig = '0;
  logic        edgeFlagClr = 0, periodEnd = 0;
  logic        pwmA = 1, pwmB = 0, brkLvlA = 0, brkLvlB = 1;
  logic        outA, outB, brakeActive, edgeFlag;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_brake_cond #(.PAIR_IDX(1), .FILT_W(FW), .BLANK_W(BW)) dut_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .cmpIn(cmpIn), .adcMon(adcMon),
    .sysFail(sysFail), .pinInvert(pinInvert), .divSel(divSel),
    .filtCount(filtCount), .edgeEn(edgeEn), .levelEn(levelEn),
    .chanOut(chanOut), .blankSrcEn(blankSrcEn), .blankType(blankType),
    .blankLen(blankLen), .swTrigWrite(swTrigWrite), .swTrig(swTrig),
    .edgeFlagClr(edgeFlagClr), .periodEnd(periodEnd), .pwmA(pwmA),
    .pwmB(pwmB), .brkLvlA(brkLvlA), .brkLvlB(brkLvlB), .outA(outA),
    .outB(outB), .brakeActive(brakeActive), .edgeFlag(edgeFlag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expBrake(input string req, input bit exp);
    check(brakeActive == exp, req, brakeActive, exp);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clearFlag();
    edgeFlagClr = 1; step(1); edgeFlagClr = 0;
  endtask

  task automatic t_reset();
    check(brakeActive == 0, "R1 brake in reset", brakeActive, 0);
    step(2); rstN = 1; step(2);
    expBrake("R1 brake after reset", 0);
    check(edgeFlag == 0, "R1 flag", edgeFlag, 0);
    check(outA == pwmA && outB == pwmB, "R1 passthrough", {outA, outB}, {pwmA, pwmB});
    pwmA = 0; pwmB = 1; step(1);
    check(outA == 0 && outB == 1, "R1 passthrough swap", {outA, outB}, 2'b01);
    pwmA = 1; pwmB = 0;
  endtask

  task automatic t_pin_edge();
    edgeEn = 6'b000001; filtCount = 3; divSel = 0;
    pinIn[0] = 1; step(3);
    expBrake("R6 not yet accepted", 0);
    step(1);
    expBrake("R6 accepted after 3 ticks", 1);
    check(outA == brkLvlA && outB == brkLvlB, "R10 forced levels", {outA, outB}, {brkLvlA, brkLvlB});
    pinIn[0] = 0; step(6);
    check(edgeFlag == 1, "R2 sticky after source gone", edgeFlag, 1);
    clearFlag();
    check(edgeFlag == 0, "R2 cleared", edgeFlag, 0);
    check(outA == pwmA, "R10 release passthrough", outA, pwmA);
    pinIn[0] = 1; step(2); pinIn[0] = 0; step(6);
    expBrake("R6 short pulse rejected", 0);
    edgeEn = '0;
  endtask

  task automatic t_invert();
    pinIn[1] = 1; pinInvert[1] = 1; edgeEn = 6'b000010; step(6);
    expBrake("R5 high pin inactive when inverted", 0);
    pinIn[1] = 0; step(4);
    expBrake("R5 low pin active when inverted", 1);
    pinIn[1] = 1; step(5); clearFlag();
    expBrake("R5 cleared", 0);
    edgeEn = '0; pinInvert = '0; pinIn[1] = 0; step(5);
  endtask

  task automatic t_divider();
    divSel = 2; filtCount = 2; edgeEn = 6'b000001;
    pinIn[0] = 1; step(4);
    expBrake("R7 divided ticks slow filter", 0);
    step(6);
    expBrake("R7 accepted on divided ticks", 1);
    pinIn[0] = 0; step(12); clearFlag();
    expBrake("R7 cleared", 0);
    divSel = 0; filtCount = 3; edgeEn = '0;
  endtask

  task automatic t_level();
    levelEn = 6'b010000;
    adcMon = 1; step(1);
    expBrake("R3 level brake on", 1);
    check(edgeFlag == 0, "R3 no latched flag", edgeFlag, 0);
    periodEnd = 1; step(1); periodEnd = 0;
    expBrake("R3 held while source active", 1);
    adcMon = 0; step(3);
    expBrake("R3 held until boundary", 1);
    periodEnd = 1; step(1); periodEnd = 0;
    expBrake("R3 released at boundary", 0);
    levelEn = '0;
  endtask

  task automatic t_disabled();
    sysFail = 1; step(3);
    expBrake("R4 disabled source ignored", 0);
    edgeEn = 6'b100000; step(1);
    expBrake("R4 bit5 is system fail", 1);
    sysFail = 0; clearFlag();
    expBrake("R4 cleared", 0);
    edgeEn = '0;
  endtask

  task automatic t_blank();
    edgeEn = 6'b000100; blankSrcEn = 3'b010; blankType = 0; blankLen = 5;
    chanOut[1] = 1; step(1);
    cmpIn[0] = 1; step(4); cmpIn[0] = 0; step(2);
    expBrake("R8 comparator blanked after rise", 0);
    cmpIn[0] = 1; step(1);
    expBrake("R8 comparator seen after window", 1);
    cmpIn[0] = 0; clearFlag();
    // system fail not blanked
    edgeEn = 6'b100100; chanOut[1] = 0; step(1); chanOut[1] = 1; step(1);
    sysFail = 1; step(1);
    expBrake("R8 system fail not blanked", 1);
    sysFail = 0; clearFlag();
    // falling type
    edgeEn = 6'b000100; blankType = 1; chanOut[1] = 0; step(1);
    cmpIn[0] = 1; step(1);
    expBrake("R8 blanked on falling edge", 0);
    cmpIn[0] = 0; step(6);
    // type 3 disables blanking
    blankType = 3; chanOut[1] = 1; step(1);
    cmpIn[0] = 1; step(1);
    expBrake("R8 type none does not blank", 1);
    cmpIn[0] = 0; clearFlag();
    // unselected channel
    blankType = 0; chanOut[0] = 1; step(1);
    cmpIn[0] = 1; step(1);
    expBrake("R8 unselected channel does not blank", 1);
    cmpIn[0] = 0; clearFlag(); chanOut = '0; edgeEn = '0; step(7);
  endtask

  task automatic t_sw();
    swTrig = 16'h0101; swTrigWrite = 1; step(1); swTrigWrite = 0; step(1);
    expBrake("R9 other pair ignored", 0);
    swTrig = 16'h0002; swTrigWrite = 1; step(1); swTrigWrite = 0;
    check(edgeFlag == 1, "R9 edge request", edgeFlag, 1);
    clearFlag();
    swTrig = 16'h0200; swTrigWrite = 1; step(1); swTrigWrite = 0;
    expBrake("R9 level request", 1);
    check(edgeFlag == 0, "R9 level not latched", edgeFlag, 0);
    periodEnd = 1; step(1); periodEnd = 0;
    expBrake("R9 level request released", 0);
  endtask

  initial begin
    t_reset();
    t_pin_edge();
    t_invert();
    t_divider();
    t_level();
    t_disabled();
    t_blank();
    t_sw();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule